// File: doc/BRIEF.md
# Transfer Control and Status Word with Error Summary

This block is the control and status word of a 16-bit block-transfer (DMA) engine. Software writes it to set the interrupt enable, the maintenance flag and a cycle-prime flag, and to issue a start command. The word reads back a single summary error bit that covers four faults: a missing bus slave response, a device attention request, a board interlock fault and a wrap of the transfer address counter. It also reads back the live levels of the device's attention and three status lines. The block owns the transfer address counter and a response timer. The timer flags a nonexistent target when the master strobe goes unanswered for a fixed time, 20 µs by default.

When the summary error bit rises, the ready flag is set. If interrupts are enabled, an interrupt request is raised and held until software issues the next start command. Each fault source has its own way of being cleared: software writes zero to the timeout flag, software reloads the address counter, the device drops its attention line, or the interlock fault goes away. An interlock fault holds the whole word in its initial state for as long as it lasts.

Top module: `xfer_csr`

## Requirements
- R1: Bit 15 (ERROR) reads 1 exactly when at least one of these is set: the timeout flag (bit 14), the sampled attention (bit 13), the interlock fault, or the address overflow flag. Software cannot write bit 15.
- R2: One cycle after ERROR rises, bit 7 (READY) reads 1. If bit 6 (IE) is 1, `irq` rises on the same edge and stays high until a CSR write with bit 0 (GO) = 1 clears both READY and `irq`. When IE is 0, `irq` stays low.
- R3: Let edge E0 be the first clock edge that samples `mst_sync` high. If `mst_sync` stays high and `slv_sync` stays low, bit 14 (NEX) reads 1 after edge E0+TMO+1, where TMO = 2000 cycles (20 µs at 100 MHz), and reads 0 before that edge. A `slv_sync` response before expiry stops the timer, and NEX stays 0.
- R4: A CSR write (`wr_sel`=0) with bit 14 = 0 clears NEX. Writing 1 to bit 14 leaves NEX unchanged. If a timer expiry and a clearing write fall on the same edge, NEX ends up set.
- R5: An `addr_inc` strobe that wraps `bus_addr` from all ones to zero sets the overflow flag. Further increments leave the flag set. Only an address write (`wr_sel`=1) clears it. A load and an increment on the same edge give the loaded value and a cleared flag.
- R6: Bit 13 shows `dev_attn`, and bits 11:9 show `dev_stat[2:0]` (bit 9 = `dev_stat[0]`), each one cycle after the input. Writes do not change these bits. A change on `dev_stat` never sets READY or `irq`.
- R7: Bit 12 (MAINT) and bit 6 (IE) are read/write.
- R8: Bit 8 (CYCLE) is read/write. A CSR write with bits 8 and 0 both set drives `cycle_start` high for exactly one cycle, on the cycle after the write, and CYCLE reads 0 from then on. A GO write with bit 8 = 0 gives no pulse. GO always reads 0.
- R9: Initialise (`rst` or `init_req`) clears NEX, MAINT, IE, CYCLE, `irq`, `bus_addr` and the overflow flag, and sets READY, so the word reads 16'h0080 with quiet inputs. While `interlock_ok` is low, initialise is held: writes have no effect, and the word reads ERROR and READY set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on initialise |
| init_req | input | 1 | Software or console initialise request |
| interlock_ok | input | 1 | Board interlock good; low is a fault |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control/status word, 1 = address counter |
| wr_data | input | 16 | Write data |
| mst_sync | input | 1 | Master sync strobe asserted by this block's bus engine |
| slv_sync | input | 1 | Slave sync response from the addressed target |
| addr_inc | input | 1 | Advance the transfer address counter by one |
| dev_attn | input | 1 | Device attention line |
| dev_stat | input | 3 | Device status lines |
| csr_rd | output | 16 | Control/status word read value |
| bus_addr | output | 16 | Transfer address counter |
| irq | output | 1 | Interrupt request level |
| cycle_start | output | 1 | One-cycle pulse that launches a bus cycle |

## Verification
Two events can land on the same edge: the response timer expiring, and a software write that clears the timeout flag. The bench raises `mst_sync` and counts exactly TMO cycles from the first edge that samples it. It then places a CSR write with bit 14 = 0 on the edge where expiry lands, and expects NEX to read 1 afterwards. A second coincidence is an address load issued together with an increment strobe. For that case the bench expects the loaded address and a cleared ERROR.

// File: rtl/xfer_csr_pkg.sv
package xfer_csr_pkg;

  localparam int B_ERR   = 15;
  localparam int B_NEX   = 14;
  localparam int B_ATTN  = 13;
  localparam int B_MAINT = 12;
  localparam int B_DSTLO = 9;
  localparam int B_CYC   = 8;
  localparam int B_RDY   = 7;
  localparam int B_IE    = 6;
  localparam int B_GO    = 0;

  typedef enum logic {
    SEL_CSR  = 1'b0,
    SEL_ADDR = 1'b1
  } wr_sel_e;

  typedef struct packed {
    logic nex;
    logic attn;
    logic ilk;
    logic ovf;
  } err_src_t;

  function automatic int tmo_cycles(longint clk_hz, longint wait_ns);
    return int'((clk_hz * wait_ns + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/xfer_live_sync.sv
module xfer_live_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         init,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (init) q[i] <= 1'b0;
      else      q[i] <= d[i];
    end
  end

endmodule

// File: rtl/xfer_resp_timer.sv
module xfer_resp_timer #(
  parameter int TMO_CYC = 2000
) (
  input  logic clk,
  input  logic init,
  input  logic mst_sync,
  input  logic slv_sync,
  output logic expire
);

  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt;
  logic          run;
  logic          mst_d;
  logic          start;

  assign start = mst_sync & ~mst_d;

  always_ff @(posedge clk) begin
    if (init) begin
      cnt    <= '0;
      run    <= 1'b0;
      mst_d  <= 1'b0;
      expire <= 1'b0;
    end else begin
      mst_d  <= mst_sync;
      expire <= 1'b0;
      if (start) begin
        cnt <= '0;
        run <= 1'b1;
      end else if (run) begin
        if (slv_sync || !mst_sync) begin
          run <= 1'b0;
        end else if (cnt == LAST) begin
          expire <= 1'b1;
          run    <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_RESP_STOPS_TIMER: assert property (@(posedge clk) disable iff (init)
    (slv_sync && !start) |=> !expire); // R3

  AST_EXPIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (init)
    expire |=> !expire); // R3

endmodule

// File: rtl/xfer_addr_ctr.sv
module xfer_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          init,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          ovf
);

  localparam logic [AW-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (init) begin
      addr <= '0;
      ovf  <= 1'b0;
    end else if (load) begin
      addr <= load_val;
      ovf  <= 1'b0;
    end else if (inc) begin
      addr <= addr + 1'b1;
      if (addr == ALL_ONES) ovf <= 1'b1;
    end
  end

  AST_LOAD_CLEARS_OVF: assert property (@(posedge clk) disable iff (init)
    load |=> !ovf); // R5

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (init)
    (inc && !load && addr == ALL_ONES) |=> (ovf && addr == '0)); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (init)
    (ovf && !load) |=> ovf); // R5

endmodule

// File: rtl/xfer_csr.sv
module xfer_csr
  import xfer_csr_pkg::*;
#(
  parameter longint CLK_HZ  = 100_000_000,
  parameter longint RESP_NS = 20_000,
  parameter int     AW      = 16,
  parameter int     DW      = 16,
  parameter int     NSTAT   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_req,
  input  logic          interlock_ok,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          mst_sync,
  input  logic          slv_sync,
  input  logic          addr_inc,
  input  logic          dev_attn,
  input  logic [NSTAT-1:0] dev_stat,
  output logic [DW-1:0] csr_rd,
  output logic [AW-1:0] bus_addr,
  output logic          irq,
  output logic          cycle_start
);

  localparam int TMO_CYC = tmo_cycles(CLK_HZ, RESP_NS);
  localparam int NLIVE   = NSTAT + 1;

  logic ilk_q;
  logic init_int;
  logic csr_wr, addr_wr;
  logic tmo_exp;
  logic ovf;
  logic [NLIVE-1:0] live_q;
  logic attn_q;
  logic [NSTAT-1:0] stat_q;

  logic nex_q, maint_q, cycle_q, ready_q, ie_q, go_q, irq_q, cyc_pulse_q;
  logic err_d;
  err_src_t src;
  logic err_now, err_rise;

  // interlock fault is sampled, then holds initialise while present
  always_ff @(posedge clk) begin
    if (rst) ilk_q <= 1'b0;
    else     ilk_q <= ~interlock_ok;
  end

  assign init_int = rst | init_req | ilk_q;
  assign csr_wr   = wr_en & (wr_sel == SEL_CSR);
  assign addr_wr  = wr_en & (wr_sel == SEL_ADDR);

  xfer_live_sync #(.W(NLIVE)) u_live (
    .clk  (clk),
    .init (init_int),
    .d    ({dev_attn, dev_stat}),
    .q    (live_q)
  );
  assign attn_q = live_q[NLIVE-1];
  assign stat_q = live_q[NSTAT-1:0];

  xfer_resp_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk      (clk),
    .init     (init_int),
    .mst_sync (mst_sync),
    .slv_sync (slv_sync),
    .expire   (tmo_exp)
  );

  xfer_addr_ctr #(.AW(AW)) u_addr (
    .clk      (clk),
    .init     (init_int),
    .load     (addr_wr),
    .load_val (wr_data[AW-1:0]),
    .inc      (addr_inc),
    .addr     (bus_addr),
    .ovf      (ovf)
  );

  always_comb begin
    src.nex  = nex_q;
    src.attn = attn_q;
    src.ilk  = ilk_q;
    src.ovf  = ovf;
  end
  assign err_now  = |src;
  assign err_rise = err_now & ~err_d;

  always_ff @(posedge clk) begin
    if (init_int) begin
      nex_q       <= 1'b0;
      maint_q     <= 1'b0;
      cycle_q     <= 1'b0;
      ie_q        <= 1'b0;
      ready_q     <= 1'b1;
      irq_q       <= 1'b0;
      go_q        <= 1'b0;
      cyc_pulse_q <= 1'b0;
      err_d       <= 1'b0;
    end else begin
      err_d       <= err_now;
      go_q        <= csr_wr & wr_data[B_GO];
      cyc_pulse_q <= 1'b0;

      // timeout flag: expiry outranks a same-edge software clear
      if (tmo_exp)                          nex_q <= 1'b1;
      else if (csr_wr && !wr_data[B_NEX])   nex_q <= 1'b0;

      if (csr_wr) begin
        maint_q <= wr_data[B_MAINT];
        ie_q    <= wr_data[B_IE];
      end

      // cycle prime: launched by the registered start
      if (go_q && cycle_q) begin
        cycle_q     <= 1'b0;
        cyc_pulse_q <= 1'b1;
      end else if (csr_wr) begin
        cycle_q <= wr_data[B_CYC];
      end

      // ready and interrupt: error edge outranks a same-edge start
      if (err_rise) begin
        ready_q <= 1'b1;
        if (ie_q) irq_q <= 1'b1;
      end else if (csr_wr && wr_data[B_GO]) begin
        ready_q <= 1'b0;
        irq_q   <= 1'b0;
      end
    end
  end

  always_comb begin
    csr_rd                          = '0;
    csr_rd[B_ERR]                   = err_now;
    csr_rd[B_NEX]                   = nex_q;
    csr_rd[B_ATTN]                  = attn_q;
    csr_rd[B_MAINT]                 = maint_q;
    csr_rd[B_DSTLO +: NSTAT]        = stat_q;
    csr_rd[B_CYC]                   = cycle_q;
    csr_rd[B_RDY]                   = ready_q;
    csr_rd[B_IE]                    = ie_q;
  end

  assign irq         = irq_q;
  assign cycle_start = cyc_pulse_q;

  AST_ERR_SETS_READY: assert property (@(posedge clk) disable iff (init_int)
    $rose(csr_rd[B_ERR]) |=> csr_rd[B_RDY]); // R2

  AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (init_int)
    irq |-> csr_rd[B_RDY]); // R2

  AST_NEX_WRITE_ONE_IGNORED: assert property (@(posedge clk) disable iff (init_int)
    (csr_wr && !tmo_exp && !csr_rd[B_NEX]) |=> !csr_rd[B_NEX]); // R4

  AST_CYCLE_CLEARS: assert property (@(posedge clk) disable iff (init_int)
    cycle_start |-> !csr_rd[B_CYC]); // R8

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (init_int)
    cycle_start |=> !cycle_start); // R8

  AST_INIT_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    init_int |=> (csr_rd[B_RDY] && !irq && !csr_rd[B_MAINT] && !csr_rd[B_NEX]
                  && !csr_rd[B_CYC] && !csr_rd[B_IE])); // R9

endmodule

// File: tb/xfer_csr_test.sv
module xfer_csr_test;

  localparam int TMO = 2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_req = 1'b0;
  logic        interlock_ok = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        mst_sync = 1'b0;
  logic        slv_sync = 1'b0;
  logic        addr_inc = 1'b0;
  logic        dev_attn = 1'b0;
  logic [2:0]  dev_stat = '0;
  logic [15:0] csr_rd;
  logic [15:0] bus_addr;
  logic        irq;
  logic        cycle_start;

  always #5 clk = ~clk;

  xfer_csr uut (
    .clk(clk), .rst(rst), .init_req(init_req), .interlock_ok(interlock_ok),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mst_sync(mst_sync), .slv_sync(slv_sync), .addr_inc(addr_inc),
    .dev_attn(dev_attn), .dev_stat(dev_stat),
    .csr_rd(csr_rd), .bus_addr(bus_addr), .irq(irq), .cycle_start(cycle_start)
  );

  typedef enum int { O_CSR, O_ADDR, O_IRQ, O_CYC } obs_e;
  typedef struct {
    obs_e        what;
    logic [15:0] mask;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic [15:0] observe(obs_e w);
    case (w)
      O_CSR:   return csr_rd;
      O_ADDR:  return bus_addr;
      O_IRQ:   return {15'd0, irq};
      default: return {15'd0, cycle_start};
    endcase
  endfunction

  task automatic expect_v(obs_e w, logic [15:0] mask, logic [15:0] exp, string tag);
    item_t it;
    it.what = w; it.mask = mask; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = observe(it.what) & it.mask;
        n_chk++;
        if (act !== (it.exp & it.mask)) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp & it.mask);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic inc_once();
    addr_inc = 1'b1;
    @(negedge clk);
    addr_inc = 1'b0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    expect_v(O_CSR, 16'hFFFF, 16'h0080, "R9 reset word");
    expect_v(O_IRQ, 16'h1, 16'h0, "R9 reset irq");
    expect_v(O_ADDR, 16'hFFFF, 16'h0000, "R9 reset addr");
    expect_v(O_CYC, 16'h1, 16'h0, "R9 reset cycle_start");

    wr(1'b0, 16'h1040);
    expect_v(O_CSR, 16'hFFFF, 16'h10C0, "R7 maint and ie written");
    wr(1'b0, 16'h5040);
    expect_v(O_CSR, 16'hFFFF, 16'h10C0, "R4 write one to NEX ignored");

    wr(1'b0, 16'h1041);
    expect_v(O_CSR, 16'hFFFF, 16'h1040, "R2 GO clears ready");
    dev_attn = 1'b1;
    tick(1);
    expect_v(O_CSR, 16'hA000, 16'hA000, "R1 R6 attention sets error");
    tick(1);
    expect_v(O_CSR, 16'hFFFF, 16'hB0C0, "R2 ready set after error");
    expect_v(O_IRQ, 16'h1, 16'h1, "R2 irq raised with IE");
    dev_attn = 1'b0;
    tick(2);
    expect_v(O_CSR, 16'hFFFF, 16'h10C0, "R1 error drops with attention");
    expect_v(O_IRQ, 16'h1, 16'h1, "R2 irq held");
    wr(1'b0, 16'h1041);
    expect_v(O_IRQ, 16'h1, 16'h0, "R2 GO clears irq");
    expect_v(O_CSR, 16'hFFFF, 16'h1040, "R2 GO clears ready again");

    dev_stat = 3'b101;
    tick(1);
    expect_v(O_CSR, 16'hFFFF, 16'h1A40, "R6 status lines visible");
    tick(1);
    expect_v(O_CSR, 16'h0080, 16'h0000, "R6 status does not set ready");
    expect_v(O_IRQ, 16'h1, 16'h0, "R6 status does not interrupt");
    dev_stat = 3'b000;
    tick(1);
    wr(1'b0, 16'h3E40);
    expect_v(O_CSR, 16'hFFFF, 16'h1040, "R6 read-only bits not writable");

    wr(1'b0, 16'h0101);
    expect_v(O_CSR, 16'hFFFF, 16'h0100, "R8 cycle primed and GO reads 0");
    expect_v(O_CYC, 16'h1, 16'h0, "R8 no pulse in write cycle");
    tick(1);
    expect_v(O_CYC, 16'h1, 16'h1, "R8 cycle_start pulse");
    expect_v(O_CSR, 16'hFFFF, 16'h0000, "R8 cycle bit cleared");
    tick(1);
    expect_v(O_CYC, 16'h1, 16'h0, "R8 pulse is one cycle");
    wr(1'b0, 16'h0001);
    tick(1);
    expect_v(O_CYC, 16'h1, 16'h0, "R8 GO without cycle gives no pulse");

    wr(1'b1, 16'hFFFE);
    expect_v(O_ADDR, 16'hFFFF, 16'hFFFE, "R5 address load");
    inc_once();
    expect_v(O_ADDR, 16'hFFFF, 16'hFFFF, "R5 increment");
    expect_v(O_CSR, 16'h8000, 16'h0000, "R5 no overflow yet");
    inc_once();
    expect_v(O_ADDR, 16'hFFFF, 16'h0000, "R5 wrap");
    expect_v(O_CSR, 16'h8000, 16'h8000, "R1 R5 overflow sets error");
    tick(1);
    expect_v(O_CSR, 16'hFFFF, 16'h8080, "R2 ready set by overflow");
    expect_v(O_IRQ, 16'h1, 16'h0, "R2 no irq while IE is 0");
    inc_once();
    expect_v(O_CSR, 16'h8000, 16'h8000, "R5 overflow stays after increment");
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h1234; addr_inc = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr_inc = 1'b0;
    expect_v(O_ADDR, 16'hFFFF, 16'h1234, "R5 load wins over increment");
    expect_v(O_CSR, 16'h8000, 16'h0000, "R5 load clears overflow");

    mst_sync = 1'b1;
    tick(1);
    tick(TMO);
    expect_v(O_CSR, 16'h4000, 16'h0000, "R3 NEX not yet set");
    wr(1'b0, 16'h0000);
    expect_v(O_CSR, 16'hC000, 16'hC000, "R3 R4 expiry wins over clear");
    mst_sync = 1'b0;
    tick(1);
    wr(1'b0, 16'h0000);
    expect_v(O_CSR, 16'hC000, 16'h0000, "R4 write zero clears NEX");

    mst_sync = 1'b1;
    tick(50);
    slv_sync = 1'b1;
    tick(TMO + 20);
    expect_v(O_CSR, 16'h4000, 16'h0000, "R3 response stops timer");
    mst_sync = 1'b0; slv_sync = 1'b0;
    tick(1);

    wr(1'b1, 16'h00AA);
    wr(1'b0, 16'h1140);
    init_req = 1'b1;
    tick(1);
    init_req = 1'b0;
    expect_v(O_CSR, 16'hFFFF, 16'h0080, "R9 init request clears word");
    expect_v(O_ADDR, 16'hFFFF, 16'h0000, "R9 init request clears address");

    wr(1'b0, 16'h1040);
    interlock_ok = 1'b0;
    tick(2);
    expect_v(O_CSR, 16'hFFFF, 16'h8080, "R1 R9 interlock fault word");
    wr(1'b0, 16'h1040);
    expect_v(O_CSR, 16'hFFFF, 16'h8080, "R9 writes ignored in fault");
    interlock_ok = 1'b1;
    tick(2);
    expect_v(O_CSR, 16'hFFFF, 16'h0080, "R9 fault removed");

    tick(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule